// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from a reset-request line, a small set of active-low external request pins and a group of active-high internal requests from on-chip peripherals. Each request is qualified by a mask register and by the service state. The block selects the most urgent one and presents its vector address to the program sequencer. Each external pin is individually programmable as level-triggered or falling-edge-triggered. One control bit chooses between nested servicing, where a more urgent request may preempt a running handler, and one-at-a-time servicing.

The sequencer accepts an offered vector by pulsing `ack_i` and ends a handler by pulsing `rti_i`. The block records every accepted source in an in-service set. Because a request can only be accepted when it outranks every source already in service, the lowest-numbered member of that set is always the innermost handler. A return therefore retires that member. Vector slots are four words apart above a configurable base, so that short handlers fit inside their slot.

Source numbering is fixed. Index 0 is the reset request. Indices 1 to N_EXT are the external pins, and the internal requests follow. A lower index always wins.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After synchronous reset the in-service set is empty and no edge is latched, so with all request inputs idle `vec_valid_o` is 0.
- R2: Source 0 (`rst_req_i` high) ignores mask bit 0 and the service mode. It is offered whenever it is not itself in service, even while other handlers run.
- R3: With `ctrl_i[k]`=0, external pin k (source k+1) requests service exactly while it is low, with no added latency and no memory.
- R4: With `ctrl_i[k]`=1, a high-to-low transition on pin k is latched one clock later and remains pending after the pin returns high. It is cleared only when source k+1 is acknowledged. A pin held low after that acknowledge does not request again.
- R5: A source other than 0 is offered only while its bit in `mask_i` is 1. A masked request stays pending and is offered as soon as it is unmasked.
- R6: Among the sources that may be offered, the lowest index is offered.
- R7: `vec_addr_o` equals VEC_BASE + 4 × `vec_src_o` whenever `vec_valid_o` is 1.
- R8: With `ctrl_i[4]`=1 (nested), while handlers are in service only sources with an index below the lowest in-service index are offered.
- R9: With `ctrl_i[4]`=0 (sequential), while any handler is in service no source other than 0 is offered.
- R10: `rti_i` removes exactly the lowest-index member of a non-empty in-service set, and less urgent pending requests become eligible again.
- R11: `ack_i` while `vec_valid_o` is 0 and `rti_i` while the in-service set is empty leave the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_req_i | input | 1 | Non-maskable reset request, source 0 |
| ext_irq_n_i | input | N_EXT | Active-low external request pins |
| int_irq_i | input | N_INT | Active-high internal peripheral requests |
| mask_i | input | NSRC | Per-source enable, 1 = enabled (bit 0 ignored) |
| ctrl_i | input | 5 | Bits N_EXT-1:0 edge select per pin, bit 4 nested mode |
| ack_i | input | 1 | Sequencer takes the offered vector |
| rti_i | input | 1 | Sequencer returns from the innermost handler |
| vec_valid_o | output | 1 | A vector is offered |
| vec_src_o | output | SRC_W | Index of the offered source |
| vec_addr_o | output | ADDR_W | Vector address of the offered source |

## Verification
The assertions assume that all request, mask and control inputs are synchronous to `clk`, since the block has no synchronizers. They also assume that the sequencer issues `ack_i` and `rti_i` as single-cycle pulses that never need to outlast a reset. The stimulus changes every input only at the falling clock edge. It combines random masks, modes, request toggles and handshake pulses (including simultaneous accept and return) with directed runs that cover edge capture, preemption and sequential blocking. Occasional mid-run resets check that the in-service state is cleared.

// File: rtl/irq_vc_pkg.sv
package irq_vc_pkg;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_EDGE  = 1'b1
    } trig_mode_e;

    localparam int unsigned NEST_CTRL_BIT = 4;
    localparam int unsigned CTRL_W        = NEST_CTRL_BIT + 1;
    localparam int unsigned SLOT_SHIFT    = 2;
    localparam int unsigned IDX_W         = 8;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } pick_t;

    // Index of the lowest set bit, zero when none is set.
    function automatic logic [IDX_W-1:0] lowest_set(input logic [255:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = 255; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

    function automatic logic [31:0] slot_addr(input logic [31:0] base,
                                              input logic [IDX_W-1:0] idx);
        return base + (32'(idx) << SLOT_SHIFT);
    endfunction

endpackage

// File: rtl/irq_vc_edge_cap.sv
module irq_vc_edge_cap
    import irq_vc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_n,
    input  trig_mode_e mode,
    input  logic       clr,
    output logic       pend_o
);
    logic prev_q;
    logic lat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
            lat_q  <= 1'b0;
        end else begin
            prev_q <= req_n;
            if (mode == TRIG_LEVEL)
                lat_q <= 1'b0;
            else if (prev_q && !req_n)
                lat_q <= 1'b1;
            else if (clr)
                lat_q <= 1'b0;
        end
    end

    assign pend_o = (mode == TRIG_EDGE) ? lat_q : !req_n;

endmodule

// File: rtl/irq_vc_arbiter.sv
module irq_vc_arbiter
    import irq_vc_pkg::*;
#(
    parameter int unsigned NSRC = 8
) (
    input  logic [NSRC-1:0] cand,
    output pick_t           pick
);
    always_comb begin
        pick.valid = |cand;
        pick.idx   = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (cand[i]) pick.idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_vc_svc_track.sv
module irq_vc_svc_track
    import irq_vc_pkg::*;
#(
    parameter int unsigned NSRC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             nest_en,
    input  logic             push,
    input  logic [IDX_W-1:0] push_idx,
    input  logic             pop,
    output logic [NSRC-1:0]  active_o,
    output logic [NSRC-1:0]  allow_o
);
    logic [NSRC-1:0]  active_q;
    logic [NSRC-1:0]  active_n;
    logic [IDX_W-1:0] low;

    assign low = lowest_set(256'(active_q));

    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            if (active_q == '0)
                allow_o[i] = 1'b1;
            else if (nest_en)
                allow_o[i] = (IDX_W'(i) < low);
            else
                allow_o[i] = (i == 0) && !active_q[0];
        end
    end

    always_comb begin
        active_n = active_q;
        if (pop && (active_q != '0)) begin
            for (int i = 0; i < NSRC; i++) begin
                if (IDX_W'(i) == low) active_n[i] = 1'b0;
            end
        end
        if (push) begin
            for (int i = 0; i < NSRC; i++) begin
                if (IDX_W'(i) == push_idx) active_n[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) active_q <= '0;
        else     active_q <= active_n;
    end

    assign active_o = active_q;

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vc_pkg::*;
#(
    parameter int unsigned N_EXT    = 3,
    parameter int unsigned N_INT    = 4,
    parameter int unsigned ADDR_W   = 14,
    parameter logic [ADDR_W-1:0] VEC_BASE = 14'h0040,
    localparam int unsigned NSRC    = 1 + N_EXT + N_INT,
    localparam int unsigned SRC_W   = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rst_req_i,
    input  logic [N_EXT-1:0]  ext_irq_n_i,
    input  logic [N_INT-1:0]  int_irq_i,
    input  logic [NSRC-1:0]   mask_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic              ack_i,
    input  logic              rti_i,
    output logic              vec_valid_o,
    output logic [SRC_W-1:0]  vec_src_o,
    output logic [ADDR_W-1:0] vec_addr_o
);
    localparam int unsigned INT_LO = 1 + N_EXT;

    logic [NSRC-1:0]  pend;
    logic [NSRC-1:0]  allow;
    logic [NSRC-1:0]  cand;
    logic [NSRC-1:0]  eff_mask;
    logic [NSRC-1:0]  svc_active;
    logic [N_EXT-1:0] edge_clr;
    logic             take;
    pick_t            pick;

    assign pend[0] = rst_req_i;

    for (genvar k = 0; k < N_EXT; k++) begin : g_ext
        irq_vc_edge_cap u_cap (
            .clk    (clk),
            .rst    (rst),
            .req_n  (ext_irq_n_i[k]),
            .mode   (trig_mode_e'(ctrl_i[k])),
            .clr    (edge_clr[k]),
            .pend_o (pend[1+k])
        );
        assign edge_clr[k] = take && (pick.idx == IDX_W'(1 + k));
    end

    assign pend[INT_LO +: N_INT] = int_irq_i;

    assign eff_mask = mask_i | NSRC'(1);
    assign cand     = pend & eff_mask & allow;

    irq_vc_arbiter #(.NSRC(NSRC)) u_arb (
        .cand (cand),
        .pick (pick)
    );

    assign take = ack_i && pick.valid;

    irq_vc_svc_track #(.NSRC(NSRC)) u_trk (
        .clk      (clk),
        .rst      (rst),
        .nest_en  (ctrl_i[NEST_CTRL_BIT]),
        .push     (take),
        .push_idx (pick.idx),
        .pop      (rti_i),
        .active_o (svc_active),
        .allow_o  (allow)
    );

    assign vec_valid_o = pick.valid;
    assign vec_src_o   = pick.idx[SRC_W-1:0];
    assign vec_addr_o  = ADDR_W'(slot_addr(32'(VEC_BASE), pick.idx));

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
    parameter int unsigned NSRC   = 8,
    parameter int unsigned SRC_W  = 3,
    parameter int unsigned ADDR_W = 14,
    parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              rst_req_i,
    input logic [NSRC-1:0]   mask_i,
    input logic [4:0]        ctrl_i,
    input logic              ack_i,
    input logic              rti_i,
    input logic              vec_valid_o,
    input logic [SRC_W-1:0]  vec_src_o,
    input logic [ADDR_W-1:0] vec_addr_o,
    input logic [NSRC-1:0]   svc_active
);
    int unsigned low_act;

    always_comb begin
        low_act = NSRC;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (svc_active[i]) low_act = i;
        end
    end

    a_r1_reset_empty: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> svc_active == '0);

    a_r2_reset_src_first: assert property (@(posedge clk) disable iff (rst)
        (rst_req_i && !svc_active[0]) |-> (vec_valid_o && vec_src_o == '0));

    a_r5_mask_respected: assert property (@(posedge clk) disable iff (rst)
        (vec_valid_o && vec_src_o != '0) |-> mask_i[vec_src_o]);

    a_r7_slot_spacing: assert property (@(posedge clk) disable iff (rst)
        vec_valid_o |-> (32'(vec_addr_o) == 32'(VEC_BASE) + 32'(vec_src_o) * 4));

    a_r8_nest_outranks: assert property (@(posedge clk) disable iff (rst)
        (ctrl_i[4] && vec_valid_o && svc_active != '0) |-> (32'(vec_src_o) < low_act));

    a_r9_seq_single: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_i[4] && vec_valid_o && svc_active != '0) |-> vec_src_o == '0);

    a_r10_pop_one: assert property (@(posedge clk) disable iff (rst)
        (rti_i && !ack_i && svc_active != '0) |=>
        ($countones(svc_active) == $countones($past(svc_active)) - 1));

    a_r11_stray_ack: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !vec_valid_o && !rti_i) |=> svc_active == $past(svc_active));

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
    .NSRC(NSRC), .SRC_W(SRC_W), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)
) u_chk (
    .clk(clk), .rst(rst), .rst_req_i(rst_req_i), .mask_i(mask_i),
    .ctrl_i(ctrl_i), .ack_i(ack_i), .rti_i(rti_i),
    .vec_valid_o(vec_valid_o), .vec_src_o(vec_src_o),
    .vec_addr_o(vec_addr_o), .svc_active(svc_active)
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
    localparam int N_EXT = 3;
    localparam int N_INT = 4;
    localparam int NSRC  = 8;
    localparam int SRC_W = 3;
    localparam int ADDR_W = 14;
    localparam int BASE  = 'h40;

    logic clk, rst, rst_req_i, ack_i, rti_i;
    logic [N_EXT-1:0] ext_irq_n_i;
    logic [N_INT-1:0] int_irq_i;
    logic [NSRC-1:0]  mask_i;
    logic [4:0]       ctrl_i;
    logic             vec_valid_o;
    logic [SRC_W-1:0] vec_src_o;
    logic [ADDR_W-1:0] vec_addr_o;

    irq_vector_ctrl u_dut (
        .clk(clk), .rst(rst), .rst_req_i(rst_req_i), .ext_irq_n_i(ext_irq_n_i),
        .int_irq_i(int_irq_i), .mask_i(mask_i), .ctrl_i(ctrl_i), .ack_i(ack_i),
        .rti_i(rti_i), .vec_valid_o(vec_valid_o), .vec_src_o(vec_src_o),
        .vec_addr_o(vec_addr_o)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    logic [N_EXT-1:0] m_edge, m_prev;
    logic [NSRC-1:0]  m_act;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    function automatic int m_low(input logic [NSRC-1:0] v);
        int r = NSRC;
        for (int i = NSRC - 1; i >= 0; i--) if (v[i]) r = i;
        return r;
    endfunction

    // Expected offered source from the requirements, -1 when none.
    function automatic int m_win();
        logic [NSRC-1:0] pend, allow, cand;
        int low = m_low(m_act);
        pend[0] = rst_req_i;
        for (int k = 0; k < N_EXT; k++)
            pend[1+k] = ctrl_i[k] ? m_edge[k] : !ext_irq_n_i[k];
        for (int j = 0; j < N_INT; j++) pend[1+N_EXT+j] = int_irq_i[j];
        for (int i = 0; i < NSRC; i++) begin
            if (m_act == '0)    allow[i] = 1'b1;
            else if (ctrl_i[4]) allow[i] = (i < low);
            else                allow[i] = (i == 0) && !m_act[0];
        end
        cand = pend & (mask_i | 8'h01) & allow;
        return (cand == '0) ? -1 : m_low(cand);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input string req);
        int w;
        int low;
        logic [NSRC-1:0] na;
        #5;
        w = m_win();
        if (!rst) begin
            chk({req, " valid"}, int'(vec_valid_o), (w >= 0) ? 1 : 0);
            if (w >= 0) begin
                chk({req, " src"}, int'(vec_src_o), w);
                chk({req, " R7 addr"}, int'(vec_addr_o), BASE + 4 * w);
            end
        end
        @(posedge clk);
        if (rst) begin
            m_edge = '0; m_prev = '1; m_act = '0;
        end else begin
            low = m_low(m_act);
            na = m_act;
            if (rti_i && m_act != '0) na[low] = 1'b0;
            if (ack_i && w >= 0) na[w] = 1'b1;
            for (int k = 0; k < N_EXT; k++) begin
                if (!ctrl_i[k])                        m_edge[k] = 1'b0;
                else if (m_prev[k] && !ext_irq_n_i[k]) m_edge[k] = 1'b1;
                else if (ack_i && w == k + 1)          m_edge[k] = 1'b0;
            end
            m_prev = ext_irq_n_i;
            m_act = na;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; rst_req_i = 0; ext_irq_n_i = '1; int_irq_i = '0;
        mask_i = '1; ctrl_i = '0; ack_i = 0; rti_i = 0;
        m_edge = '0; m_prev = '1; m_act = '0;
        @(negedge clk);
        tick("R1"); tick("R1");
        rst = 0;
        tick("R1"); tick("R1");
        // R3 level pin 1 -> source 2
        ext_irq_n_i[1] = 0; tick("R3"); tick("R3");
        ext_irq_n_i[1] = 1; tick("R3");
        // R4 edge pin 0 -> source 1
        ctrl_i[0] = 1; ext_irq_n_i[0] = 0; tick("R4"); tick("R4");
        ext_irq_n_i[0] = 1; tick("R4");
        ack_i = 1; tick("R4"); ack_i = 0;
        tick("R9");
        rti_i = 1; tick("R10"); rti_i = 0;
        tick("R4");
        ext_irq_n_i[0] = 0; tick("R4"); tick("R4");
        ack_i = 1; tick("R4"); ack_i = 0;
        rti_i = 1; tick("R4"); rti_i = 0;
        tick("R4"); tick("R4");
        ext_irq_n_i[0] = 1; tick("R4");
        // R5 mask hold on source 5
        mask_i[5] = 0; int_irq_i[1] = 1; tick("R5"); tick("R5");
        mask_i[5] = 1; tick("R5");
        // R6 priority among 4, 5, 7
        int_irq_i[3] = 1; int_irq_i[0] = 1; tick("R6");
        // R8 nested
        ctrl_i[4] = 1; ack_i = 1; tick("R8"); ack_i = 0;
        tick("R8");
        ext_irq_n_i[2] = 0; tick("R8");
        ack_i = 1; tick("R8"); ack_i = 0;
        tick("R8");
        rst_req_i = 1; tick("R2"); rst_req_i = 0;
        ext_irq_n_i[2] = 1;
        rti_i = 1; tick("R10"); rti_i = 0;
        tick("R10");
        rti_i = 1; tick("R10"); rti_i = 0;
        tick("R10");
        // R9 sequential
        ctrl_i[4] = 0; ack_i = 1; tick("R9"); ack_i = 0;
        ext_irq_n_i[1] = 0; tick("R9");
        rst_req_i = 1; mask_i[0] = 0; tick("R2"); rst_req_i = 0; mask_i[0] = 1;
        ext_irq_n_i[1] = 1; rti_i = 1; tick("R10"); rti_i = 0;
        // R11 stray handshakes
        int_irq_i = '0; tick("R11");
        ack_i = 1; tick("R11"); ack_i = 0;
        rti_i = 1; tick("R11"); rti_i = 0;
        int_irq_i[2] = 1; tick("R11");
        int_irq_i = '0; tick("R11");
        // Random mix
        void'($urandom(32'h5eed_1234));
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(7) == 0) ext_irq_n_i[$urandom_range(N_EXT-1)] ^= 1'b1;
            if ($urandom_range(7) == 0) int_irq_i[$urandom_range(N_INT-1)] ^= 1'b1;
            if ($urandom_range(31) == 0) mask_i = NSRC'($urandom);
            if ($urandom_range(63) == 0) ctrl_i = 5'($urandom);
            rst_req_i = ($urandom_range(63) == 0);
            ack_i = ($urandom_range(2) == 0);
            rti_i = ($urandom_range(3) == 0);
            rst = ($urandom_range(499) == 0);
            tick("R6/R8/R9 random");
        end
        rst = 0;
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule